// File: doc/BRIEF.md
# Vector Gather Operand Decoder

This block sits behind the prefix and VEX parsers of an instruction decoder and handles the memory operand of the four vector gather opcodes. It is handed a command: the low opcode bit, the ModRM and SIB bytes, the REX extension bits, the VEX W, L and effective vvvv values, the segment and mode state, and whether a segment override was seen. From these it builds one 28-bit parameter word for the gather execution unit. It names the destination, index vector, mask and base registers. It also carries the scale, the operand size, the address mode, the effective segment and three width flags.

A gather always uses a SIB byte in memory form. Encodings that do not follow that shape are rejected with a one-cycle invalid-opcode pulse. When the ModRM mod field calls for a displacement, the block takes the displacement bytes, least significant first, from a valid/ready byte stream, one byte per cycle. It then reports a one-cycle done pulse together with the parameter word and a 32-bit sign-extended displacement. Both values are held until the next command is accepted.

Top module: `gather_operand_decoder`

## Requirements
- R1: After reset, `done`, `undef`, `busy` and `byte_ready` are all low.
- R2: A command with ModRM mod = 3 gives a one-cycle `undef` pulse in the cycle after `start`, with no `done`, and `byte_ready` stays low (no byte is consumed).
- R3: A command whose ModRM rm field (bits [2:0]) is not 4 is rejected exactly as in R2.
- R4: A legal command with mod = 0 gives `done` in the cycle after `start`, with `disp` = 0 and no byte consumed.
- R5: With mod = 1, exactly one byte is taken and `disp` is that byte sign-extended to 32 bits. `done` rises in the cycle after the byte is taken.
- R6: With mod = 2, four bytes are taken and `disp` is assembled least significant byte first. `done` rises in the cycle after the fourth byte is taken.
- R7: The parameter word packs these fields:
  - dst = {rex_r, ModRM[5:3]} in bits [3:0].
  - index = {rex_x, SIB[5:3]} in bits [7:4].
  - mask = vvvv in bits [11:8].
  - base = {rex_b, SIB[2:0]} in bits [15:12].
  - scale = SIB[7:6] in bits [17:16].
  - op_size in bits [19:18].
  - addr_mode in bits [21:20].
  - segment in bits [24:22].
  - the 256-bit flag in bit 25.
  - the index-qword flag in bit 26.
  - the value-qword flag in bit 27.
- R8: The segment field is 2 (SS) when the 4-bit base is 4 or 5 and `seg_override` is low. In every other case, including bases 12 and 13 and any overridden command, it is `seg_in`.
- R9: The value-qword flag equals `vex_w`, the index-qword flag equals `opc_odd` (the opcode's bit 0), and the 256-bit flag equals `vex_l`.
- R10: `byte_ready` is high only while the block is busy fetching. A cycle with `byte_valid` low takes no byte and delays `done`.
- R11: `start` is ignored while `busy` is high. The outstanding command's parameters and displacement are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command valid; accepted when not busy |
| opc_odd | input | 1 | Opcode bit 0 (1 = qword indices) |
| modrm | input | 8 | ModRM byte |
| sib | input | 8 | SIB byte |
| rex_r | input | 1 | Extension of ModRM reg |
| rex_x | input | 1 | Extension of SIB index |
| rex_b | input | 1 | Extension of SIB base |
| vex_w | input | 1 | VEX W (qword values) |
| vex_l | input | 1 | VEX L (256-bit) |
| vex_vvvv | input | 4 | Effective (un-inverted) vvvv |
| seg_override | input | 1 | A segment override prefix was present |
| seg_in | input | 3 | Current effective segment |
| op_size | input | 2 | Effective operand size code |
| addr_mode | input | 2 | Effective address mode code |
| byte_valid | input | 1 | Displacement byte valid |
| byte_data | input | 8 | Displacement byte |
| byte_ready | output | 1 | Block takes a byte this cycle |
| busy | output | 1 | Fetching displacement bytes |
| done | output | 1 | One-cycle pulse: operand complete |
| undef | output | 1 | One-cycle pulse: invalid encoding |
| params | output | 28 | Packed parameter word |
| disp | output | 32 | Sign-extended displacement |

## Verification
The bench drives the byte 0x80 through the one-byte form. A decoder that zero-extends would report 0x00000080 instead of 0xFFFFFF80, and one that reversed the four-byte order would return 0x78563412 for bytes 78 56 34 12.

Segment selection is probed at bases 4 and 5 with and without an override, and at bases 12 and 13. A design that ignored REX.B in the SP/BP test would wrongly switch those to SS.

Rejected encodings are checked for a single `undef` with no `done` and no ready byte lane. A stall in the byte stream must delay `done`, and a second `start` issued mid-fetch must not overwrite the held parameter word.

// File: rtl/gath_pkg.sv
package gath_pkg;

    localparam int REG_W   = 4;
    localparam int SEG_W   = 3;
    localparam int MODE_W  = 2;
    localparam int SCALE_W = 2;
    localparam int DISP_W  = 32;
    localparam int DISP_BYTES = DISP_W / 8;
    localparam int CNT_W   = $clog2(DISP_BYTES + 1);
    localparam int PARAM_W = 4 * REG_W + SCALE_W + 2 * MODE_W + SEG_W + 3;

    localparam logic [SEG_W-1:0] SEG_STACK = 3'd2;
    localparam logic [REG_W-1:0] GPR_STACKPTR = 4'd4;
    localparam logic [REG_W-1:0] GPR_FRAMEPTR = 4'd5;

    typedef enum logic [0:0] {ST_IDLE, ST_FETCH} gd_state_e;

    // Field order is behaviour: the execution unit decodes these positions.
    typedef struct packed {
        logic               val_qw;
        logic               idx_qw;
        logic               wide;
        logic [SEG_W-1:0]   seg;
        logic [MODE_W-1:0]  amode;
        logic [MODE_W-1:0]  osize;
        logic [SCALE_W-1:0] scale;
        logic [REG_W-1:0]   base;
        logic [REG_W-1:0]   mask;
        logic [REG_W-1:0]   index;
        logic [REG_W-1:0]   dst;
    } gd_params_t;

    // Memory form with a SIB byte is the only legal shape.
    function automatic logic enc_legal(input logic [7:0] mrm);
        return (mrm[7:6] != 2'b11) && (mrm[2:0] == 3'd4);
    endfunction

    function automatic logic [CNT_W-1:0] disp_len(input logic [1:0] md);
        case (md)
            2'b01:   return CNT_W'(1);
            2'b10:   return CNT_W'(DISP_BYTES);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gd_field_extract.sv
module gd_field_extract
    import gath_pkg::*;
(
    input  logic              opc_odd,
    input  logic [7:0]        modrm,
    input  logic [7:0]        sib,
    input  logic              rex_r,
    input  logic              rex_x,
    input  logic              rex_b,
    input  logic              vex_w,
    input  logic              vex_l,
    input  logic [REG_W-1:0]  vex_vvvv,
    input  logic              seg_override,
    input  logic [SEG_W-1:0]  seg_in,
    input  logic [MODE_W-1:0] op_size,
    input  logic [MODE_W-1:0] addr_mode,
    output gd_params_t        fields
);
    logic [REG_W-1:0] base_reg;
    logic             stack_base;

    assign base_reg   = {rex_b, sib[2:0]};
    assign stack_base = (base_reg == GPR_STACKPTR) || (base_reg == GPR_FRAMEPTR);

    always_comb begin
        fields.dst    = {rex_r, modrm[5:3]};
        fields.index  = {rex_x, sib[5:3]};
        fields.mask   = vex_vvvv;
        fields.base   = base_reg;
        fields.scale  = sib[7:6];
        fields.osize  = op_size;
        fields.amode  = addr_mode;
        fields.seg    = (stack_base && !seg_override) ? SEG_STACK : seg_in;
        fields.wide   = vex_l;
        fields.idx_qw = opc_odd;
        fields.val_qw = vex_w;
    end
endmodule

// File: rtl/gd_disp_collect.sv
module gd_disp_collect
    import gath_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              short_form,
    input  logic              take,
    input  logic [CNT_W-1:0]  lane,
    input  logic [7:0]        data,
    output logic [DISP_W-1:0] disp
);
    logic [DISP_W-1:0] raw;
    logic              short_q;

    always_ff @(posedge clk) begin
        if (rst || clear) short_q <= clear && short_form;
    end

    for (genvar g = 0; g < DISP_BYTES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst || clear)
                raw[8*g +: 8] <= '0;
            else if (take && (lane == CNT_W'(g)))
                raw[8*g +: 8] <= data;
        end
    end

    assign disp = short_q ? {{(DISP_W-8){raw[7]}}, raw[7:0]} : raw;
endmodule

// File: rtl/gather_operand_decoder.sv
module gather_operand_decoder
    import gath_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                opc_odd,
    input  logic [7:0]          modrm,
    input  logic [7:0]          sib,
    input  logic                rex_r,
    input  logic                rex_x,
    input  logic                rex_b,
    input  logic                vex_w,
    input  logic                vex_l,
    input  logic [REG_W-1:0]    vex_vvvv,
    input  logic                seg_override,
    input  logic [SEG_W-1:0]    seg_in,
    input  logic [MODE_W-1:0]   op_size,
    input  logic [MODE_W-1:0]   addr_mode,
    input  logic                byte_valid,
    input  logic [7:0]          byte_data,
    output logic                byte_ready,
    output logic                busy,
    output logic                done,
    output logic                undef,
    output logic [PARAM_W-1:0]  params,
    output logic [DISP_W-1:0]   disp
);
    gd_state_e        state;
    gd_params_t       fields, params_q;
    logic [CNT_W-1:0] need_q, cnt_q, need_now;
    logic             done_q, undef_q, accept, legal, take, last;

    gd_field_extract u_fields (
        .opc_odd(opc_odd), .modrm(modrm), .sib(sib),
        .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b),
        .vex_w(vex_w), .vex_l(vex_l), .vex_vvvv(vex_vvvv),
        .seg_override(seg_override), .seg_in(seg_in),
        .op_size(op_size), .addr_mode(addr_mode), .fields(fields)
    );

    assign accept   = start && (state == ST_IDLE);
    assign legal    = enc_legal(modrm);
    assign need_now = disp_len(modrm[7:6]);
    assign take     = byte_ready && byte_valid;
    assign last     = (cnt_q + CNT_W'(1)) == need_q;

    gd_disp_collect u_disp (
        .clk(clk), .rst(rst),
        .clear(accept && legal),
        .short_form(need_now == CNT_W'(1)),
        .take(take), .lane(cnt_q), .data(byte_data),
        .disp(disp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            done_q   <= 1'b0;
            undef_q  <= 1'b0;
            cnt_q    <= '0;
            need_q   <= '0;
            params_q <= '0;
        end else begin
            done_q  <= 1'b0;
            undef_q <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    if (!legal) begin
                        undef_q <= 1'b1;
                    end else begin
                        params_q <= fields;
                        cnt_q    <= '0;
                        need_q   <= need_now;
                        if (need_now == '0) done_q <= 1'b1;
                        else                state  <= ST_FETCH;
                    end
                end
                ST_FETCH: if (take) begin
                    cnt_q <= cnt_q + CNT_W'(1);
                    if (last) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign byte_ready = (state == ST_FETCH);
    assign busy       = (state == ST_FETCH);
    assign done       = done_q;
    assign undef      = undef_q;
    assign params     = params_q;
endmodule

// File: rtl/gd_checker.sv
module gd_checker
    import gath_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [7:0]         modrm,
    input logic               busy,
    input logic               byte_valid,
    input logic               byte_ready,
    input logic               done,
    input logic               undef,
    input logic [PARAM_W-1:0] params
);
    p_ready_only_busy_r10: assert property (@(posedge clk) disable iff (rst)
        byte_ready |-> busy);

    p_undef_from_start_r2: assert property (@(posedge clk) disable iff (rst)
        undef |-> $past(start && !busy && !enc_legal(modrm)));

    p_undef_no_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        undef |-> (!done && !byte_ready));

    p_done_cause_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(start && !busy && modrm[7:6] == 2'b00)
                  || $past(byte_valid && byte_ready)));

    p_params_hold_r11: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> $stable(params));
endmodule

bind gather_operand_decoder gd_checker u_chk (
    .clk(clk), .rst(rst), .start(start), .modrm(modrm), .busy(busy),
    .byte_valid(byte_valid), .byte_ready(byte_ready),
    .done(done), .undef(undef), .params(params)
);

// File: tb/sim_gather_operand_decoder.sv
`timescale 1ns/1ps
module sim_gather_operand_decoder;
    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic opc_odd = 0, rex_r = 0, rex_x = 0, rex_b = 0, vex_w = 0, vex_l = 0, seg_override = 0;
    logic [7:0] modrm = 8'h04, sib = 8'h00, byte_data = 8'h00;
    logic [3:0] vex_vvvv = 4'd0;
    logic [2:0] seg_in = 3'd3;
    logic [1:0] op_size = 2'd1, addr_mode = 2'd2;
    logic byte_valid = 1'b0;
    logic byte_ready, busy, done, undef;
    logic [27:0] params;
    logic [31:0] disp;
    int checks = 0, errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    gather_operand_decoder u0 (
        .clk(clk), .rst(rst), .start(start), .opc_odd(opc_odd), .modrm(modrm), .sib(sib),
        .rex_r(rex_r), .rex_x(rex_x), .rex_b(rex_b), .vex_w(vex_w), .vex_l(vex_l),
        .vex_vvvv(vex_vvvv), .seg_override(seg_override), .seg_in(seg_in),
        .op_size(op_size), .addr_mode(addr_mode), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_ready(byte_ready), .busy(busy), .done(done),
        .undef(undef), .params(params), .disp(disp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] exp_params();
        logic [3:0] b;
        logic [2:0] s;
        b = {rex_b, sib[2:0]};
        s = ((b == 4'd4 || b == 4'd5) && !seg_override) ? 3'd2 : seg_in;
        return {vex_w, opc_odd, vex_l, s, addr_mode, op_size, sib[7:6], b, vex_vvvv,
                rex_x, sib[5:3], rex_r, modrm[5:3]};
    endfunction

    task automatic fire();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic feed(input logic [7:0] b);
        byte_valid = 1'b1;
        byte_data  = b;
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 done", done, 0); chk("R1 undef", undef, 0);
        chk("R1 busy", busy, 0); chk("R1 ready", byte_ready, 0);
    endtask

    task automatic t_reject(input string req, input logic [7:0] m);
        modrm = m;
        fire();
        chk({req, " undef"}, undef, 1); chk({req, " done"}, done, 0);
        chk({req, " ready"}, byte_ready, 0);
        @(negedge clk);
        chk({req, " undef pulse"}, undef, 0); chk({req, " busy"}, busy, 0);
    endtask

    task automatic t_mod0();
        modrm = 8'b00_101_100; sib = 8'b10_011_001; rex_r = 1; rex_x = 1; rex_b = 0;
        vex_vvvv = 4'hA; vex_w = 1; vex_l = 0; opc_odd = 1; seg_override = 0;
        fire();
        chk("R4 done", done, 1); chk("R4 disp", disp, 0); chk("R4 ready", byte_ready, 0);
        chk("R7 params", params, exp_params());
        chk("R9 flags", params[27:25], {3'b110});
        @(negedge clk);
        chk("R4 pulse", done, 0);
        vex_w = 0; vex_l = 1; opc_odd = 0; sib = 8'b01_110_111;
        fire();
        chk("R9 flags b", params[27:25], {3'b001});
        chk("R7 params b", params, exp_params());
    endtask

    task automatic t_disp8(input logic [7:0] b, input logic [31:0] exp);
        modrm = 8'b01_010_100; sib = 8'h1B;
        fire();
        chk("R5 busy", busy, 1); chk("R5 no done", done, 0);
        feed(b);
        chk("R5 done", done, 1); chk("R5 disp", disp, exp);
        chk("R10 ready idle", byte_ready, 0);
    endtask

    task automatic t_disp32();
        modrm = 8'b10_001_100; sib = 8'h22;
        fire();
        feed(8'h78); feed(8'h56);
        repeat (3) @(negedge clk);
        chk("R10 stall busy", busy, 1); chk("R10 stall done", done, 0);
        feed(8'h34);
        chk("R6 not yet", done, 0);
        feed(8'h12);
        chk("R6 done", done, 1); chk("R6 disp", disp, 32'h12345678);
        chk("R7 params", params, exp_params());
    endtask

    task automatic t_segment(input logic rb, input logic [2:0] bl, input logic ov);
        modrm = 8'h04; rex_b = rb; sib = {5'b00_000, bl}; seg_override = ov; seg_in = 3'd5;
        fire();
        chk("R8 seg", params[24:22], exp_params() >> 22 & 28'h7);
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        logic [27:0] held;
        modrm = 8'b10_011_100; sib = 8'h0D; rex_b = 0; seg_override = 0;
        fire();
        held = exp_params();
        modrm = 8'b00_111_100; sib = 8'hC0;
        fire();
        chk("R11 no done", done, 0); chk("R11 busy", busy, 1);
        feed(8'h01); feed(8'h02); feed(8'h03); feed(8'h84);
        chk("R11 done", done, 1); chk("R11 params", params, held);
        chk("R11 disp", disp, 32'h84030201);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        // idle byte_valid has no effect (R10)
        feed(8'h55);
        chk("R10 idle", byte_ready, 0);
        t_reject("R2", 8'b11_000_100);
        t_reject("R3", 8'b00_000_101);
        t_reject("R3", 8'b10_000_000);
        t_mod0();
        @(negedge clk);
        t_disp8(8'h80, 32'hFFFFFF80);
        t_disp8(8'h7F, 32'h0000007F);
        t_disp32();
        t_segment(0, 3'd4, 0);
        t_segment(0, 3'd5, 0);
        t_segment(0, 3'd4, 1);
        t_segment(1, 3'd4, 0);
        t_segment(1, 3'd5, 0);
        t_segment(0, 3'd3, 0);
        t_busy_ignore();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule